// File: doc/BRIEF.md
# Preamble pattern sequencer

This block draws bytes from a small first-word-fall-through byte queue that holds the preamble and desync part of a frame. It treats them as a stream of pattern sequences and sends out one single-bit symbol for each accepted transmit strobe, most significant bit first. Each sequence opens with a command byte. Bit 7 of that byte selects one of two modes. In single mode the pattern bits are sent once. In repeat mode a short pattern is sent over and over. The low seven bits give the number of symbols.

In repeat mode a second byte gives the repetition count. The pattern, at most four bytes long, is popped from the queue once and kept in local registers. It is then played back from those registers for each repetition. A polarity input inverts every symbol on its way out.

When the queue runs dry between sequences the block lowers its valid flag and waits. When the queue runs dry inside a sequence the block also waits, and it sets a sticky underflow flag.

Top module: `preamble_seq`

## Requirements
- R1: In a command byte, bit 7 = 0 selects single mode and bits 6..0 give the symbol count N. The block then pops ceil(N/8) data bytes and sends exactly N symbols, taking each byte MSB first.
- R2: The unused low bits of a final partial data byte are dropped. The next byte in the queue is read as a new command byte.
- R3: A command byte with bit 7 = 1 selects repeat mode, and bits 6..0 give the pattern length L. The following byte gives the repetition count R. Then ceil(L/8) pattern bytes follow, and the L-symbol pattern is sent R times back to back.
- R4: Pattern bytes are popped once only. No byte is popped while a symbol is being offered (sym_valid high).
- R5: A repeat length above 32 is treated as 32, so four pattern bytes are consumed.
- R6: A symbol count of 0 in either mode produces no output. In single mode only the command byte is consumed; in repeat mode the command byte and the count byte are consumed. A repetition count of 0 consumes the pattern bytes and produces no output.
- R7: While invert is 1, every symbol on sym_out is the complement of the pattern bit.
- R8: A symbol advances only in a cycle where sym_valid and sym_ready are both high. Otherwise sym_valid stays high and sym_out keeps its value.
- R9: If the queue is empty where a command byte is due, sym_valid is low and underflow is not set.
- R10: If the queue is empty where a count, pattern or data byte is due, sym_valid is low and underflow goes to 1. Underflow stays at 1 until reset. The sequence resumes when bytes arrive.
- R11: fifo_pop is never high while fifo_empty is high.
- R12: After reset, sym_valid and underflow are 0 and the block waits for a command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_empty | input | 1 | Queue holds no byte |
| fifo_data | input | 8 | Byte at the head of the queue |
| fifo_pop | output | 1 | Consume the head byte at this clock edge |
| invert | input | 1 | Invert output symbols |
| sym_ready | input | 1 | Transmit strobe; accepts the offered symbol |
| sym_valid | output | 1 | A symbol is offered on sym_out |
| sym_out | output | 1 | Current symbol |
| underflow | output | 1 | Sticky: the queue ran dry inside a sequence |

## Verification
The assertions check four things on every cycle. A stalled symbol holds its value. The underflow flag never clears. The block never pops an empty queue. No byte is consumed while a symbol is on offer, which is how the one-time load of the repeat pattern shows at the ports. The bench scenarios cover the rest. Only they can show the decoded symbol streams: MSB-first order, dropping of the leftover bits, the repeat count, clamping of long patterns, skipping of zero counts, inversion, and the difference between an empty queue at a command boundary and one inside a sequence.

// File: rtl/preamble_seq.sv
module preamble_seq #(
  parameter int MAX_PAT = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_data,
  output logic       fifo_pop,
  input  logic       invert,
  input  logic       sym_ready,
  output logic       sym_valid,
  output logic       sym_out,
  output logic       underflow
);
  localparam int PAT_BYTES = MAX_PAT / 8;
  localparam int IDX_W = $clog2(MAX_PAT);
  localparam int LW = IDX_W + 1;
  localparam int LB_W = (PAT_BYTES > 1) ? $clog2(PAT_BYTES) : 1;

  typedef enum logic [2:0] {S_CMD, S_REPS, S_LOAD, S_FETCH, S_SSEND, S_RSEND} st_t;

  st_t             st;
  logic [6:0]      remain;
  logic [2:0]      sbit;
  logic [7:0]      sh;
  logic [LW-1:0]   plen;
  logic [7:0]      reps;
  logic [IDX_W-1:0] pidx;
  logic [LB_W-1:0] lidx;
  logic [7:0]      pat_b [PAT_BYTES];

  wire need = (st == S_CMD) || (st == S_REPS) || (st == S_LOAD) || (st == S_FETCH);
  wire mid  = need && (st != S_CMD);
  assign fifo_pop  = need && !fifo_empty;
  assign sym_valid = (st == S_SSEND) || (st == S_RSEND);
  wire fire = sym_valid && sym_ready;

  wire pat_bit = pat_b[pidx[IDX_W-1:3]][3'd7 - pidx[2:0]];
  assign sym_out = ((st == S_RSEND) ? pat_bit : sh[7]) ^ invert;

  wire [6:0]    cnt_in   = fifo_data[6:0];
  wire [LW-1:0] plen_in  = (cnt_in > 7'(MAX_PAT)) ? LW'(MAX_PAT) : LW'(cnt_in);
  wire [LW-1:0] nb_m1    = ((plen + LW'(7)) >> 3) - LW'(1);
  wire          last_ld  = (LW'(lidx) == nb_m1);
  wire          last_sym = (LW'(pidx) == plen - LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_CMD;
      remain    <= '0;
      sbit      <= '0;
      sh        <= '0;
      plen      <= '0;
      reps      <= '0;
      pidx      <= '0;
      lidx      <= '0;
      underflow <= 1'b0;
      for (int i = 0; i < PAT_BYTES; i++) pat_b[i] <= '0;
    end else begin
      if (mid && fifo_empty) underflow <= 1'b1;
      case (st)
        S_CMD: if (!fifo_empty) begin
          if (fifo_data[7]) begin
            plen <= plen_in;
            st   <= S_REPS;
          end else begin
            remain <= cnt_in;
            st     <= (cnt_in == 7'd0) ? S_CMD : S_FETCH;
          end
        end
        S_REPS: if (!fifo_empty) begin
          reps <= fifo_data;
          lidx <= '0;
          pidx <= '0;
          st   <= (plen == '0) ? S_CMD : S_LOAD;
        end
        S_LOAD: if (!fifo_empty) begin
          pat_b[lidx] <= fifo_data;
          if (last_ld) st <= (reps == 8'd0) ? S_CMD : S_RSEND;
          else lidx <= lidx + LB_W'(1);
        end
        S_FETCH: if (!fifo_empty) begin
          sh   <= fifo_data;
          sbit <= '0;
          st   <= S_SSEND;
        end
        S_SSEND: if (fire) begin
          sh     <= {sh[6:0], 1'b0};
          sbit   <= sbit + 3'd1;
          remain <= remain - 7'd1;
          if (remain == 7'd1) st <= S_CMD;
          else if (sbit == 3'd7) st <= S_FETCH;
        end
        S_RSEND: if (fire) begin
          if (last_sym) begin
            pidx <= '0;
            reps <= reps - 8'd1;
            if (reps == 8'd1) st <= S_CMD;
          end else begin
            pidx <= pidx + IDX_W'(1);
          end
        end
        default: st <= S_CMD;
      endcase
    end
  end
endmodule

// File: rtl/preamble_seq_chk.sv
module preamble_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic fifo_empty,
  input logic fifo_pop,
  input logic invert,
  input logic sym_ready,
  input logic sym_valid,
  input logic sym_out,
  input logic underflow
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && !sym_ready |=> sym_valid && ((sym_out ^ invert) == $past(sym_out ^ invert))); // R8
  AST_UFL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow); // R10
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !fifo_pop); // R11
  AST_NO_POP_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |-> !fifo_pop); // R4
endmodule

bind preamble_seq preamble_seq_chk u_chk (.*);

// File: tb/preamble_seq_bench.sv
module preamble_seq_bench;
  logic clk = 0, rst_n = 0, invert = 0, sym_ready = 1;
  logic fifo_pop, sym_valid, sym_out, underflow, fifo_empty;
  logic [7:0] fifo_data;
  logic [7:0] mem [256];
  logic [7:0] rd_ptr = 0, wr_ptr = 0;
  logic cap [1024];
  int ncap = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign fifo_empty = (rd_ptr == wr_ptr);
  assign fifo_data  = mem[rd_ptr];

  always @(posedge clk) if (fifo_pop) rd_ptr <= rd_ptr + 8'd1;
  always @(posedge clk) if (rst_n && sym_valid && sym_ready) begin
    cap[ncap] <= sym_out;
    ncap <= ncap + 1;
  end

  preamble_seq u_preamble_seq (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_pop(fifo_pop), .invert(invert), .sym_ready(sym_ready),
    .sym_valid(sym_valid), .sym_out(sym_out), .underflow(underflow));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_bits(string req, int start, string exp);
    string act = "";
    for (int i = start; i < ncap; i++) act = {act, cap[i] ? "1" : "0"};
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  task automatic push(logic [7:0] b);
    mem[wr_ptr] = b;
    wr_ptr = wr_ptr + 8'd1;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    settle(3);
    rst_n = 1;
    settle(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 valid after reset", sym_valid, 0);
    chk("R12 underflow after reset", underflow, 0);
    chk("R12 no pop when idle", fifo_pop, 0);
  endtask

  task automatic t_single();
    int s = ncap;
    @(negedge clk);
    push(8'h0C); push(8'hA5); push(8'h3F);
    settle(60);
    chk_bits("R1 R2 single 12 symbols", s, "101001010011");
    chk("R9 idle valid low", sym_valid, 0);
    chk("R9 no underflow at boundary", underflow, 0);
  endtask

  task automatic t_repeat();
    int s = ncap;
    @(negedge clk);
    push(8'h83); push(8'h04); push(8'hA0);
    settle(60);
    chk_bits("R3 repeat 3x4", s, "101101101101");
    chk("R4 queue drained once", fifo_empty, 1);
  endtask

  task automatic t_clamp();
    int s = ncap;
    string p = "11011110101011011011111011101111";
    @(negedge clk);
    push(8'hA8); push(8'h02);
    push(8'hDE); push(8'hAD); push(8'hBE); push(8'hEF);
    push(8'h02); push(8'hC0);
    settle(150);
    chk_bits("R5 clamp to 32 then next command", s, {p, p, "11"});
  endtask

  task automatic t_zero();
    int s = ncap;
    @(negedge clk);
    push(8'h00);
    push(8'h80); push(8'h05);
    push(8'h81); push(8'h00); push(8'hFF);
    push(8'h01); push(8'h80);
    settle(60);
    chk_bits("R6 zero counts skipped", s, "1");
    chk("R6 all bytes consumed", fifo_empty, 1);
  endtask

  task automatic t_invert();
    int s = ncap;
    @(negedge clk);
    invert = 1;
    push(8'h04); push(8'h90);
    settle(40);
    chk_bits("R7 inverted symbols", s, "0110");
    invert = 0;
  endtask

  task automatic t_backpressure();
    int s = ncap;
    int bad = 0;
    logic pv, pr, po;
    @(negedge clk);
    push(8'h0A); push(8'hC3); push(8'h40);
    pv = 0; pr = 1; po = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (pv && !pr && (!sym_valid || sym_out != po)) bad++;
      sym_ready = (i % 3 == 2);
      pv = sym_valid; pr = sym_ready; po = sym_out;
    end
    sym_ready = 1;
    settle(10);
    chk("R8 symbol held while stalled", bad, 0);
    chk_bits("R8 stream under stalls", s, "1100001101");
  endtask

  task automatic t_underflow();
    int s = ncap;
    @(negedge clk);
    push(8'h10); push(8'hA5);
    settle(40);
    chk_bits("R10 bits before starvation", s, "10100101");
    chk("R10 valid low while starved", sym_valid, 0);
    chk("R10 underflow set", underflow, 1);
    push(8'h3C);
    settle(40);
    chk_bits("R10 resume after refill", s, "1010010100111100");
    chk("R10 underflow sticky", underflow, 1);
    do_reset();
    chk("R12 reset clears underflow", underflow, 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_repeat();
    t_clamp();
    t_zero();
    t_invert();
    t_backpressure();
    t_underflow();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule